// File: doc/BRIEF.md
# Accumulator Datapath with Status Flags

This block is the arithmetic heart of a small accumulator machine. It holds an accumulator register, a second operand register and three status flags: zero, signed overflow and carry. Every clock cycle in which the enable is high, a packed 12-bit command word tells it what to do. The command picks an ALU operation on the accumulator, picks where the second operand comes from, optionally loads the operand register, and optionally clears flags.

Instruction fetch, opcode decode, the program counter and the memories are outside the block. The surrounding control unit supplies the command, the word just read from data memory and an immediate or data value. It takes the accumulator output as the data for stores and the flags for conditional branches.

The design is split into a combinational command decoder and a registered datapath. The decoder turns the command into a small strobe record that the datapath consumes.

Top module: `accum_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, A, B and all three flags become 0 on that edge. This happens whatever `en` and `cmd` are.
- R2: When `en` is low (and `rst` low), A, B and the three flags keep their values across the edge.
- R3: Command layout: `cmd[11:10]` is the B-load field, `cmd[9:7]` the flag-clear field, `cmd[6]` is ignored, `cmd[5:2]` is the ALU operation and `cmd[1:0]` the operand select. Operand select 00 picks `memRd`, 01 picks `dataIn`, 10 picks register B and 11 picks the constant 1.
- R4: Operation 0000 sets A to A + operand, C to the carry out and OV to signed overflow. Operation 0001 sets A to A − operand, C to 1 when no borrow occurs (A ≥ operand unsigned) and OV to signed overflow.
- R5: Operation 0100 is AND and 0101 is OR, both with the operand. 0110 is XOR with the operand. 1100 inverts A and 1001 negates A in two's complement. 1101 clears A and 0011 loads A with the operand. None of these change C or OV.
- R6: Operation 0111 shifts A right arithmetically, keeping the sign bit, with C taking A[0]. Operation 1000 sets A to {A[7], A[5:0], 0}, with C taking A[6]. Operation 1010 shifts A left logically, with C taking A[7]. Operation 1011 shifts A right logically, with C taking A[0]. OV is unchanged by all four.
- R7: Operation 1110 rotates right through carry: A becomes {C, A[7:1]} and C becomes A[0]. Operation 1111 rotates left through carry: A becomes {A[6:0], C} and C becomes A[7]. OV is unchanged by both.
- R8: Operation 0010 leaves A and all three flags unchanged.
- R9: Every operation other than 0010 sets Z to 1 exactly when the new 8-bit value of A is zero.
- R10: B-load field 01 loads B from `dataIn` and 11 loads B from `memRd`. Fields 00 and 10 leave B unchanged. An ALU operation that selects B in the same cycle uses the old B.
- R11: Flag-clear bit `cmd[9]` clears C, `cmd[8]` clears OV and `cmd[7]` clears Z. A cleared flag is 0 after the edge even if the ALU operation of that cycle would have set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for all registers |
| cmd | input | 12 | Packed command word |
| memRd | input | DATA_W | Value read from data memory |
| dataIn | input | DATA_W | Immediate or direct data value |
| accOut | output | DATA_W | Accumulator A (also store data) |
| bOut | output | DATA_W | Operand register B |
| zFlag | output | 1 | Zero flag |
| ovFlag | output | 1 | Signed overflow flag |
| cFlag | output | 1 | Carry flag |

## Verification
The bench builds the block with the default width of 8 bits. At that width the bit positions named in the requirements are the literal positions the shifts and rotates use, and random operands reach the signed and unsigned boundaries of addition and subtraction often. A behavioural model computes A, B and the flags with integer arithmetic and is compared after every edge. Directed sequences hit 0x7F+1, 0xFF+1, borrow on subtraction, and a clear on the same cycle as a setting operation. They also cover an enable-low stretch and a B load combined with a B-selecting operation. A long random stretch then covers every operation, operand source and field combination.

// File: rtl/accum_pkg.sv
package accum_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_HOLD = 4'b0010,
    OP_LOAD = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_SRA  = 4'b0111,
    OP_SLA  = 4'b1000,
    OP_NEG  = 4'b1001,
    OP_SLL  = 4'b1010,
    OP_SRL  = 4'b1011,
    OP_NOT  = 4'b1100,
    OP_CLR  = 4'b1101,
    OP_RRC  = 4'b1110,
    OP_RLC  = 4'b1111
  } aluOp_e;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'b00,
    SEL_DATA = 2'b01,
    SEL_B    = 2'b10,
    SEL_ONE  = 2'b11
  } opndSel_e;

  typedef struct packed {
    aluOp_e   op;
    opndSel_e sel;
    logic     loadB;
    logic     bFromMem;
    logic     clrZ;
    logic     clrOv;
    logic     clrC;
    logic     writeA;
    logic     updC;
    logic     updOv;
  } strobe_t;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int CMD_W = 12
) (
  input  logic [CMD_W-1:0] cmd,
  output strobe_t          stb
);
  localparam int B_LSB  = CMD_W - 2;
  localparam int CLR_HI = CMD_W - 3;

  always_comb begin
    stb          = '0;
    stb.op       = aluOp_e'(cmd[5:2]);
    stb.sel      = opndSel_e'(cmd[1:0]);
    stb.loadB    = cmd[B_LSB];
    stb.bFromMem = cmd[B_LSB+1];
    stb.clrC     = cmd[CLR_HI];
    stb.clrOv    = cmd[CLR_HI-1];
    stb.clrZ     = cmd[CLR_HI-2];
    stb.writeA   = (stb.op != OP_HOLD);
    unique case (stb.op)
      OP_ADD, OP_SUB: begin stb.updC = 1'b1; stb.updOv = 1'b1; end
      OP_SRA, OP_SLA, OP_SLL, OP_SRL, OP_RRC, OP_RLC: stb.updC = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] memRd,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] accQ,
  output logic [DATA_W-1:0] bQ,
  output logic              zQ,
  output logic              ovQ,
  output logic              cQ
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opnd, res;
  logic              cyOut, ovOut;
  logic [DATA_W:0]   wide;

  always_comb begin
    unique case (stb.sel)
      SEL_MEM:  opnd = memRd;
      SEL_DATA: opnd = dataIn;
      SEL_B:    opnd = bQ;
      default:  opnd = DATA_W'(1);
    endcase
  end

  always_comb begin
    res   = accQ;
    cyOut = cQ;
    ovOut = ovQ;
    wide  = '0;
    unique case (stb.op)
      OP_ADD: begin
        wide  = {1'b0, accQ} + {1'b0, opnd};
        res   = wide[MSB:0];
        cyOut = wide[DATA_W];
        ovOut = (accQ[MSB] == opnd[MSB]) && (res[MSB] != accQ[MSB]);
      end
      OP_SUB: begin
        wide  = {1'b0, accQ} - {1'b0, opnd};
        res   = wide[MSB:0];
        cyOut = ~wide[DATA_W];
        ovOut = (accQ[MSB] != opnd[MSB]) && (res[MSB] != accQ[MSB]);
      end
      OP_HOLD: res = accQ;
      OP_LOAD: res = opnd;
      OP_AND:  res = accQ & opnd;
      OP_OR:   res = accQ | opnd;
      OP_XOR:  res = accQ ^ opnd;
      OP_NOT:  res = ~accQ;
      OP_NEG:  res = ~accQ + DATA_W'(1);
      OP_CLR:  res = '0;
      OP_SRA:  begin res = {accQ[MSB], accQ[MSB:1]};          cyOut = accQ[0];     end
      OP_SLA:  begin res = {accQ[MSB], accQ[MSB-2:0], 1'b0};  cyOut = accQ[MSB-1]; end
      OP_SLL:  begin res = {accQ[MSB-1:0], 1'b0};             cyOut = accQ[MSB];   end
      OP_SRL:  begin res = {1'b0, accQ[MSB:1]};               cyOut = accQ[0];     end
      OP_RRC:  begin res = {cQ, accQ[MSB:1]};                 cyOut = accQ[0];     end
      OP_RLC:  begin res = {accQ[MSB-1:0], cQ};               cyOut = accQ[MSB];   end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
      bQ   <= '0;
      zQ   <= 1'b0;
      ovQ  <= 1'b0;
      cQ   <= 1'b0;
    end else if (en) begin
      if (stb.writeA) accQ <= res;
      if (stb.loadB)  bQ   <= stb.bFromMem ? memRd : dataIn;
      if (stb.clrZ)        zQ  <= 1'b0;
      else if (stb.writeA) zQ  <= (res == '0);
      if (stb.clrOv)       ovQ <= 1'b0;
      else if (stb.updOv)  ovQ <= ovOut;
      if (stb.clrC)        cQ  <= 1'b0;
      else if (stb.updC)   cQ  <= cyOut;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (accQ == '0 && bQ == '0 && !zQ && !ovQ && !cQ));

  a_r2_enable_low_holds: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(accQ) && $stable(bQ) && $stable(zQ) && $stable(ovQ) && $stable(cQ)));

  a_r8_hold_op_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (en && stb.op == OP_HOLD && !stb.clrZ && !stb.clrOv && !stb.clrC)
      |=> ($stable(accQ) && $stable(zQ) && $stable(ovQ) && $stable(cQ)));

  a_r9_zero_tracks_acc: assert property (@(posedge clk) disable iff (rst)
    (en && stb.writeA && !stb.clrZ) |=> (zQ == (accQ == '0)));

  a_r10_b_kept_without_load: assert property (@(posedge clk) disable iff (rst)
    (en && !stb.loadB) |=> $stable(bQ));

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (en && (stb.clrZ || stb.clrOv || stb.clrC))
      |=> ((!$past(stb.clrZ) || !zQ) && (!$past(stb.clrOv) || !ovQ) && (!$past(stb.clrC) || !cQ)));

endmodule

// File: rtl/accum_unit.sv
module accum_unit
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [11:0]       cmd,
  input  logic [DATA_W-1:0] memRd,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic              zFlag,
  output logic              ovFlag,
  output logic              cFlag
);
  strobe_t stb;

  accum_ctrl #(.CMD_W(12)) u_ctrl (
    .cmd (cmd),
    .stb (stb)
  );

  accum_core #(.DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .stb    (stb),
    .memRd  (memRd),
    .dataIn (dataIn),
    .accQ   (accOut),
    .bQ     (bOut),
    .zQ     (zFlag),
    .ovQ    (ovFlag),
    .cQ     (cFlag)
  );

endmodule

// File: tb/sim_accum_unit.sv
module sim_accum_unit;
  localparam int W    = 8;
  localparam int MASK = 255;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [11:0]  cmd = '0;
  logic [W-1:0] memRd = '0, dataIn = '0;
  logic [W-1:0] accOut, bOut;
  logic         zFlag, ovFlag, cFlag;

  int checks = 0, errors = 0;
  int mA = 0, mB = 0, mZ = 0, mO = 0, mC = 0;
  bit done = 0;

  always #5 clk = ~clk;

  accum_unit #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .cmd(cmd), .memRd(memRd), .dataIn(dataIn),
    .accOut(accOut), .bOut(bOut), .zFlag(zFlag), .ovFlag(ovFlag), .cFlag(cFlag)
  );

  function automatic logic [11:0] mk(int bl, int fl, int op, int sel);
    return {2'(bl), 3'(fl), 1'b0, 4'(op), 2'(sel)};
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // behavioural reference: next state from the current model state
  task automatic model(input bit r, input bit e, input logic [11:0] c, input int mem, input int dat);
    int o, op, res, nc, no, s;
    bit wr;
    if (r) begin mA = 0; mB = 0; mZ = 0; mO = 0; mC = 0; return; end
    if (!e) return;
    op = int'(c[5:2]);
    case (c[1:0])
      2'd0: o = mem;
      2'd1: o = dat;
      2'd2: o = mB;
      default: o = 1;
    endcase
    res = mA; nc = mC; no = mO; wr = 1;
    case (op)
      0:  begin s = mA + o; res = s % 256; nc = (s > MASK); s = sgn(mA) + sgn(o); no = (s > 127 || s < -128); end
      1:  begin s = mA - o; res = (s + 256) % 256; nc = (mA >= o); s = sgn(mA) - sgn(o); no = (s > 127 || s < -128); end
      2:  wr = 0;
      3:  res = o;
      4:  res = mA & o;
      5:  res = mA | o;
      6:  res = mA ^ o;
      7:  begin res = (mA / 2) + (mA >= 128 ? 128 : 0); nc = mA % 2; end
      8:  begin res = (mA & 128) + ((mA * 2) & 127); nc = (mA / 64) % 2; end
      9:  res = (256 - mA) % 256;
      10: begin res = (mA * 2) % 256; nc = mA / 128; end
      11: begin res = mA / 2; nc = mA % 2; end
      12: res = MASK - mA;
      13: res = 0;
      14: begin res = (mA / 2) + mC * 128; nc = mA % 2; end
      default: begin res = ((mA * 2) % 256) + mC; nc = mA / 128; end
    endcase
    if (c[11:10] == 2'b01) mB = dat;
    else if (c[11:10] == 2'b11) mB = mem;
    if (wr) mA = res;
    if (c[7]) mZ = 0; else if (wr) mZ = (res == 0);
    if (c[8]) mO = 0; else mO = no;
    if (c[9]) mC = 0; else mC = nc;
  endtask

  task automatic step(input string tag, input bit r, input bit e, input logic [11:0] c,
                      input int mem, input int dat);
    @(negedge clk);
    rst = r; en = e; cmd = c; memRd = W'(mem); dataIn = W'(dat);
    model(r, e, c, mem, dat);
    @(posedge clk);
    #1;
    checks++;
    if (int'(accOut) != mA || int'(bOut) != mB || int'(zFlag) != mZ ||
        int'(ovFlag) != mO || int'(cFlag) != mC) begin
      errors++;
      $display("FAIL %s cmd=%03h: A=%02h B=%02h Z%0d OV%0d C%0d expected A=%02h B=%02h Z%0d OV%0d C%0d",
               tag, c, accOut, bOut, zFlag, ovFlag, cFlag, mA, mB, mZ, mO, mC);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step("R1 reset", 1, 0, 12'h000, 0, 0);
    // load A and B then reset again
    step("R3 load data", 0, 1, mk(1, 0, 3, 1), 0, 8'h5A);
    step("R1 reset after load", 1, 1, mk(1, 0, 0, 1), 3, 3);
    // operand selects with add
    step("R10 load B from data", 0, 1, mk(1, 0, 2, 0), 8'h11, 8'h22);
    step("R3 add mem", 0, 1, mk(0, 0, 0, 0), 8'h10, 8'h99);
    step("R3 add data", 0, 1, mk(0, 0, 0, 1), 8'h77, 8'h01);
    step("R3 add B", 0, 1, mk(0, 0, 0, 2), 8'h77, 8'h77);
    step("R3 inc const one", 0, 1, mk(0, 0, 0, 3), 8'h77, 8'h77);
    step("R3 dec const one", 0, 1, mk(0, 0, 1, 3), 0, 0);
    // add/sub boundaries
    step("R4 load 7F", 0, 1, mk(0, 0, 3, 1), 0, 8'h7F);
    step("R4 7F+1 overflow", 0, 1, mk(0, 0, 0, 3), 0, 0);
    step("R4 load FF", 0, 1, mk(0, 0, 3, 0), 8'hFF, 0);
    step("R4 FF+1 carry zero", 0, 1, mk(0, 0, 0, 3), 0, 0);
    step("R4 0-6 borrow", 0, 1, mk(0, 0, 1, 1), 0, 6);
    step("R4 sub no borrow", 0, 1, mk(0, 0, 1, 0), 8'h05, 0);
    step("R4 load 80", 0, 1, mk(0, 0, 3, 1), 0, 8'h80);
    step("R4 80-1 overflow", 0, 1, mk(0, 0, 1, 3), 0, 0);
    // logic and unary ops
    step("R5 and B", 0, 1, mk(0, 0, 4, 2), 0, 0);
    step("R5 or mem", 0, 1, mk(0, 0, 5, 0), 8'hA0, 0);
    step("R5 xor data", 0, 1, mk(0, 0, 6, 1), 0, 8'h3C);
    step("R5 not", 0, 1, mk(0, 0, 12, 0), 0, 0);
    step("R5 neg", 0, 1, mk(0, 0, 9, 0), 0, 0);
    step("R5 clear acc", 0, 1, mk(0, 0, 13, 0), 0, 0);
    // shifts and rotates
    step("R6 load C3", 0, 1, mk(0, 0, 3, 1), 0, 8'hC3);
    step("R6 sra", 0, 1, mk(0, 0, 7, 0), 0, 0);
    step("R6 sla", 0, 1, mk(0, 0, 8, 0), 0, 0);
    step("R6 sll", 0, 1, mk(0, 0, 10, 0), 0, 0);
    step("R6 srl", 0, 1, mk(0, 0, 11, 0), 0, 0);
    step("R7 load 81", 0, 1, mk(0, 0, 3, 1), 0, 8'h81);
    step("R7 rrc", 0, 1, mk(0, 0, 14, 0), 0, 0);
    step("R7 rrc again", 0, 1, mk(0, 0, 14, 0), 0, 0);
    step("R7 rlc", 0, 1, mk(0, 0, 15, 0), 0, 0);
    step("R7 rlc again", 0, 1, mk(0, 0, 15, 0), 0, 0);
    // hold op and enable low
    step("R8 hold op", 0, 1, mk(0, 0, 2, 1), 8'hFF, 8'hFF);
    step("R2 enable low", 0, 0, mk(3, 7, 13, 0), 8'h12, 8'h34);
    step("R2 enable low again", 0, 0, mk(1, 0, 0, 3), 8'h12, 8'h34);
    // B load field corner cases
    step("R10 load B mem", 0, 1, mk(3, 0, 2, 0), 8'h44, 8'h55);
    step("R10 field 10 ignored", 0, 1, mk(2, 0, 2, 0), 8'h66, 8'h77);
    step("R10 old B used", 0, 1, mk(1, 0, 3, 2), 0, 8'h99);
    // flag clears against setting ops
    step("R11 load FF", 0, 1, mk(0, 0, 3, 0), 8'hFF, 0);
    step("R11 clear C with carry", 0, 1, mk(0, 4, 0, 3), 0, 0);
    step("R11 clear Z with zero", 0, 1, mk(0, 1, 13, 0), 0, 0);
    step("R11 load 7F", 0, 1, mk(0, 0, 3, 1), 0, 8'h7F);
    step("R11 clear OV with overflow", 0, 1, mk(0, 2, 0, 3), 0, 0);
    step("R9 zero on load", 0, 1, mk(0, 0, 3, 0), 0, 0);
    // random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] c;
      c = 12'($urandom);
      step($sformatf("R9 random op %0d", int'(c[5:2])), ($urandom % 97) == 0,
           ($urandom % 8) != 0, c, int'($urandom % 256), int'($urandom % 256));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule